// File: doc/BRIEF.md
# Zero-Crossing Triggered Switch Sequencer

This block drives the switch network of a synchronized-switch rectifier for a piezoelectric harvester. The sequence starts when the current-direction comparator output rises. The transducer capacitance is first shorted for a counted interval. The block then samples the sign of the transducer voltage and recharges that capacitance from the storage capacitor through one of two polarity paths. Last, it hands the node back to the active diode so that power extraction can run until the next crossing. The sequence starts from the comparator edge, not from a fixed period, so it follows any excitation frequency.

All timing is counted in cycles of a slow free-running clock; with a 125 kHz clock each cycle is 8 µs and the default phase lengths of four cycles give 32 µs. The comparator and polarity inputs are asynchronous and are synchronized inside the block. The outputs are decoded from a small phase state machine. A one-cycle pause with both the short and the share switch open separates the phases that drive those switches.

Top module: `zc_switch_seq`

## Requirements
- R1: While reset is asserted and after its release, before any crossing edge, the outputs are {diode_en, short_en, share_en, swap_pos, swap_neg} = 1,0,0,0,0.
- R2: A rising edge on zc_in, first seen at clock edge k, puts the block in the shorting phase after edge k+2: short_en=1, swap_pos=1, swap_neg=1, diode_en=0, share_en=0.
- R3: The shorting phase lasts exactly SHORT_CYCLES clock cycles (default 4).
- R4: The shorting phase is followed by exactly one cycle with diode_en, short_en and share_en all 0 and both swap outputs still 1.
- R5: The sharing phase then lasts exactly SHARE_CYCLES cycles (default 4), with share_en=1 and exactly one swap output high. swap_pos is high if the synchronized pol_in was 1 (positive) in the last shorting cycle; swap_neg is high if it was 0.
- R6: The sharing phase is followed by exactly one cycle with diode_en, short_en and share_en all 0 and the selected swap output held.
- R7: The extraction phase follows that pause: diode_en=1, and the selected swap output stays high until the next sequence starts.
- R8: Rising edges of zc_in that arrive during a sequence are ignored, and falling edges of zc_in never change the outputs.
- R9: short_en and share_en are never high in the same cycle, and diode_en is 0 whenever either is high.
- R10: A change on pol_in after the last shorting cycle has no effect on the swap outputs of that sequence.
- R11: Asserting rst_n low during a sequence returns the outputs at once to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow free-running phase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| zc_in | input | 1 | Comparator output; rising edge marks a zero crossing (asynchronous) |
| pol_in | input | 1 | Sign of transducer voltage, 1 = positive (asynchronous) |
| diode_en | output | 1 | Allows the active diode to conduct |
| short_en | output | 1 | Closes the switch shorting the transducer capacitance |
| share_en | output | 1 | Closes the switch linking storage to the transducer |
| swap_pos | output | 1 | Positive polarity path select |
| swap_neg | output | 1 | Negative polarity path select |

## Verification
The hardest cases to reach from the ports are a polarity sample taken at the end of the shorting phase rather than at the trigger, and a second comparator edge that falls inside a running sequence. The vector table places pol_in changes in exact cycles relative to the first shorting cycle. One change lands early enough to pass the two-stage synchronizer before the sample is taken, and one lands after it. Other vectors drop and raise zc_in during the shorting phase, so that the synchronized rising edge reaches the state machine while it is in the pause or sharing phase. A directed test pulls reset in the middle of sharing.

// File: rtl/zcs_pkg.sv
package zcs_pkg;

  typedef enum logic [2:0] {
    ST_EXTRACT = 3'd0,
    ST_SHORT   = 3'd1,
    ST_GAP_A   = 3'd2,
    ST_SHARE   = 3'd3,
    ST_GAP_B   = 3'd4
  } zcs_state_t;

endpackage

// File: rtl/zcs_sync.sv
module zcs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stage_q[i] <= stage_q[i-1];
      stage_q[0] <= din;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/zcs_phase_timer.sv
module zcs_phase_timer #(
  parameter int COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/zcs_out_decode.sv
module zcs_out_decode
  import zcs_pkg::*;
(
  input  zcs_state_t state,
  input  logic       pol_sel,
  input  logic       sel_valid,
  output logic       diode_en,
  output logic       short_en,
  output logic       share_en,
  output logic       swap_pos,
  output logic       swap_neg
);

  always_comb begin
    diode_en = 1'b0;
    short_en = 1'b0;
    share_en = 1'b0;
    swap_pos = 1'b0;
    swap_neg = 1'b0;
    case (state)
      ST_EXTRACT: begin
        diode_en = 1'b1;
        swap_pos = sel_valid & pol_sel;
        swap_neg = sel_valid & ~pol_sel;
      end
      ST_SHORT: begin
        short_en = 1'b1;
        swap_pos = 1'b1;
        swap_neg = 1'b1;
      end
      ST_GAP_A: begin
        swap_pos = 1'b1;
        swap_neg = 1'b1;
      end
      ST_SHARE: begin
        share_en = 1'b1;
        swap_pos = pol_sel;
        swap_neg = ~pol_sel;
      end
      ST_GAP_B: begin
        swap_pos = pol_sel;
        swap_neg = ~pol_sel;
      end
      default: diode_en = 1'b1;
    endcase
  end

endmodule

// File: rtl/zc_switch_seq.sv
module zc_switch_seq
  import zcs_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int SHARE_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_in,
  input  logic pol_in,
  output logic diode_en,
  output logic short_en,
  output logic share_en,
  output logic swap_pos,
  output logic swap_neg
);

  localparam int NUM_ASYNC = 2;

  zcs_state_t state_q, state_d;
  logic [NUM_ASYNC-1:0] async_s;
  logic zc_s, pol_s, zc_prev_q, zc_rise;
  logic short_done, share_done;
  logic pol_q, pol_d, sel_q, sel_d, pol_load;

  zcs_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({pol_in, zc_in}),
    .dout (async_s)
  );

  assign zc_s  = async_s[0];
  assign pol_s = async_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_prev_q <= 1'b0;
    else        zc_prev_q <= zc_s;
  end

  assign zc_rise = zc_s & ~zc_prev_q;

  zcs_phase_timer #(.COUNT(SHORT_CYCLES)) u_short_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_SHORT),
    .done (short_done)
  );

  zcs_phase_timer #(.COUNT(SHARE_CYCLES)) u_share_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_SHARE),
    .done (share_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_EXTRACT: if (zc_rise)    state_d = ST_SHORT;
      ST_SHORT:   if (short_done) state_d = ST_GAP_A;
      ST_GAP_A:                   state_d = ST_SHARE;
      ST_SHARE:   if (share_done) state_d = ST_GAP_B;
      ST_GAP_B:                   state_d = ST_EXTRACT;
      default:                    state_d = ST_EXTRACT;
    endcase
  end

  assign pol_load = (state_q == ST_SHORT) && short_done;
  assign pol_d    = pol_load ? pol_s : pol_q;
  assign sel_d    = pol_load | sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EXTRACT;
      pol_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pol_q   <= pol_d;
      sel_q   <= sel_d;
    end
  end

  zcs_out_decode u_decode (
    .state    (state_q),
    .pol_sel  (pol_q),
    .sel_valid(sel_q),
    .diode_en (diode_en),
    .short_en (short_en),
    .share_en (share_en),
    .swap_pos (swap_pos),
    .swap_neg (swap_neg)
  );

endmodule

// File: rtl/zcs_checks.sv
module zcs_checks #(
  parameter int SHORT_CYCLES = 4,
  parameter int SHARE_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic diode_en,
  input logic short_en,
  input logic share_en,
  input logic swap_pos,
  input logic swap_neg
);

  logic [15:0] short_run, share_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_run <= '0;
      share_run <= '0;
    end else begin
      short_run <= short_en ? short_run + 1'b1 : '0;
      share_run <= share_en ? share_run + 1'b1 : '0;
    end
  end

  assert_short_share_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_en && share_en));

  assert_diode_off_in_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (short_en || share_en) |-> !diode_en);

  assert_short_opens_swaps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_en) |-> (swap_pos && swap_neg));

  assert_short_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_en) |-> (short_run == 16'(SHORT_CYCLES)));

  assert_gap_after_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_en) |-> (!share_en && !diode_en && swap_pos && swap_neg));

  assert_share_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(share_en) |-> (share_run == 16'(SHARE_CYCLES)));

  assert_share_one_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    share_en |-> $onehot({swap_pos, swap_neg}));

  assert_gap_after_share_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(share_en) |-> (!diode_en && !short_en && $stable({swap_pos, swap_neg})));

  assert_path_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(share_en) && !short_en) |-> $stable({swap_pos, swap_neg}));

endmodule

bind zc_switch_seq zcs_checks #(
  .SHORT_CYCLES(SHORT_CYCLES),
  .SHARE_CYCLES(SHARE_CYCLES)
) u_checks (.*);

// File: tb/zc_switch_seq_test.sv
module zc_switch_seq_test;

  localparam int NSHORT = 4;
  localparam int NSHARE = 4;
  localparam int SEQ_LAST = NSHORT + NSHARE + 2;
  localparam int NVEC = 6;

  // vector: {pol, early_flip, late_flip, mid_pulse, hold_high[7:0], hold_low[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  8'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd20},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  8'd2},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd30, 8'd5},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd2,  8'd40},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'd6,  8'd6}
  };

  logic clk = 1'b0;
  logic rst_n, zc_in, pol_in;
  logic diode_en, short_en, share_en, swap_pos, swap_neg;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  zc_switch_seq #(.SHORT_CYCLES(NSHORT), .SHARE_CYCLES(NSHARE)) uut (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .pol_in(pol_in),
    .diode_en(diode_en), .short_en(short_en), .share_en(share_en),
    .swap_pos(swap_pos), .swap_neg(swap_neg)
  );

  task automatic check(input logic [4:0] exp, input string req);
    logic [4:0] act;
    act = {diode_en, short_en, share_en, swap_pos, swap_neg};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_at(input int i, input logic p);
    if (i < NSHORT)               return 5'b01011;       // R2 R3
    if (i == NSHORT)              return 5'b00011;       // R4
    if (i <= NSHORT + NSHARE)     return {3'b001, p, ~p}; // R5
    if (i == NSHORT + NSHARE + 1) return {3'b000, p, ~p}; // R6
    return {3'b100, p, ~p};                               // R7
  endfunction

  function automatic string req_at(input int i);
    if (i < NSHORT)               return "R3";
    if (i == NSHORT)              return "R4";
    if (i <= NSHORT + NSHARE)     return "R5";
    if (i == NSHORT + NSHARE + 1) return "R6";
    return "R7";
  endfunction

  task automatic run_seq(input logic [19:0] v);
    logic p;
    p = v[19] ^ v[18];
    pol_in = v[19];
    repeat (3) @(negedge clk);
    zc_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i <= SEQ_LAST; i++) begin
      check(expect_at(i, p), req_at(i));
      if (i == 0 && v[18]) pol_in = ~pol_in;
      if (i == NSHORT + 2 && v[17]) pol_in = ~pol_in;   // R10
      if (i == 1 && v[16]) zc_in = 1'b0;                // R8
      if (i == 3 && v[16]) zc_in = 1'b1;                // R8
      @(negedge clk);
    end
    for (int i = 0; i < int'(v[15:8]); i++) begin
      check({3'b100, p, ~p}, "R8");
      @(negedge clk);
    end
    zc_in = 1'b0;
    for (int i = 0; i < int'(v[7:0]); i++) begin
      check({3'b100, p, ~p}, "R8");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    zc_in = 1'b0;
    pol_in = 1'b0;
    repeat (3) @(negedge clk);
    check(5'b10000, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(5'b10000, "R1");

    for (int n = 0; n < NVEC; n++) run_seq(VEC[n]);

    // R11: reset in the middle of sharing
    pol_in = 1'b1;
    repeat (3) @(negedge clk);
    zc_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    repeat (NSHORT + 2) @(negedge clk);
    check({3'b001, 2'b10}, "R5");
    rst_n = 1'b0;
    zc_in = 1'b0;
    #1;
    check(5'b10000, "R11");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(5'b10000, "R11");
    end

    // fresh sequence after the reset, negative polarity
    run_seq({1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'd2});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule